// File: doc/BRIEF.md
# Six-Instruction Multicycle Processor

This block is a small stored-program processor. It holds its program and its data in two internal 256-word memories. A program counter steps through the program memory, and every instruction passes through three controller phases in turn: fetch, decode and execute. The datapath has a sixteen-entry register file and an adder/subtractor. A two-way write-back select feeds the register file either from data memory or from the arithmetic unit. Arithmetic operates only on register contents. Moving values between memory and registers takes explicit load and store instructions.

Software or a testbench fills both memories through a load port while `run` is low, releases reset and raises `run`. The same port reads either memory back afterwards. Lowering `run` freezes the controller, the program counter and all writes. This lets a host stop a program between phases and inspect the memories.

Top module: `mcp_top`

## Requirements
- R1: After reset is released, `pc` is 0 and `phase` is 0 (fetch). The phase encoding is fetch=0, decode=1, execute=2.
- R2: While `run` is high, `phase` cycles fetch, decode, execute, fetch, one step per clock, so each instruction takes exactly three clocks. `pc` goes up by one on the clock that leaves fetch. While `run` is low, `phase`, `pc` and all register and memory contents hold.
- R3: An instruction is 16 bits with the opcode in bits [15:12]. Opcode 0x0 loads register [11:8] from the data word at address [7:0]. Opcode 0x1 stores register [11:8] to the data address [7:0].
- R4: Opcode 0x2 writes register [11:8] with register [7:4] plus register [3:0]. Opcode 0x4 writes the difference. Both wrap modulo 2^16.
- R5: Opcode 0x3 writes the 8-bit value in [7:0], zero-extended to 16 bits, into register [11:8].
- R6: Opcode 0x5 tests register [11:8]. If it is zero, the next instruction comes from the jump's own address plus the two's-complement offset in [7:0], and backward jumps are allowed. Otherwise execution continues at the following address.
- R7: Opcodes 0x6 through 0xF change no register and no data word.
- R8: With `ld_en` high, `ld_data` is written at `ld_addr` into the data memory when `ld_sel`=1 and into the program memory when `ld_sel`=0. `rd_data` combinationally shows the word at `rd_addr` of the memory chosen by `ld_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Advance the controller when high |
| ld_en | input | 1 | Write strobe of the load port |
| ld_sel | input | 1 | Memory select: 1 data, 0 program |
| ld_addr | input | 8 | Load port word address |
| ld_data | input | 16 | Load port write data |
| rd_addr | input | 8 | Readback address |
| rd_data | output | 16 | Readback data from the selected memory |
| pc | output | 8 | Program counter |
| phase | output | 2 | Controller phase (0 fetch, 1 decode, 2 execute) |

## Verification
Registers are visible only through the data memory. Every check therefore passes through a program that stores results, and the program must end in a self-loop so that stopping at any point leaves a stable image. The hardest case is a backward relative jump, because only a taken backward branch can reach its target. The stimulus jumps over a store-and-loop block and then branches back into it, so the stored marker appears only if the negative offset is applied correctly. Random operand pairs sit alongside zero, equal and wrapping pairs that drive the taken/not-taken choice and the arithmetic wrap. A no-op with a random opcode sits between the arithmetic and its stores, with fields that would corrupt a result if it were decoded.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  localparam int ADDR_W = 8;
  localparam int OPC_W  = 4;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'd0,
    ALU_SUB   = 2'd1,
    ALU_PASSK = 2'd2
  } alu_op_t;

  localparam logic [OPC_W-1:0] OP_LD  = 4'h0;
  localparam logic [OPC_W-1:0] OP_ST  = 4'h1;
  localparam logic [OPC_W-1:0] OP_ADD = 4'h2;
  localparam logic [OPC_W-1:0] OP_LDK = 4'h3;
  localparam logic [OPC_W-1:0] OP_SUB = 4'h4;
  localparam logic [OPC_W-1:0] OP_JZ  = 4'h5;
endpackage

// File: rtl/mcp_mem.sv
module mcp_mem #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata_a = arr[raddr_a];
  assign rdata_b = arr[raddr_b];
endmodule

// File: rtl/mcp_regfile.sv
module mcp_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wsel,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] sel_a,
  input  logic [$clog2(NREG)-1:0] sel_b,
  input  logic [$clog2(NREG)-1:0] sel_c,
  output logic [DW-1:0]           val_a,
  output logic [DW-1:0]           val_b,
  output logic [DW-1:0]           val_c
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[wsel] <= wdata;
  end

  assign val_a = regs[sel_a];
  assign val_b = regs[sel_b];
  assign val_c = regs[sel_c];
endmodule

// File: rtl/mcp_alu.sv
module mcp_alu
  import mcp_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_t       op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] konst,
  output logic [DW-1:0] res
);
  always_comb begin
    unique case (op)
      ALU_SUB:   res = opa - opb;
      ALU_PASSK: res = konst;
      default:   res = opa + opb;
    endcase
  end
endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
  import mcp_pkg::*;
#(
  parameter int IW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [IW-1:0] instr,
  input  logic          ra_zero,
  output logic [PW-1:0] pc,
  output phase_t        phase,
  output logic [IW-1:0] ir,
  output logic          rf_we,
  output logic          dm_we,
  output logic          wb_mem,
  output alu_op_t       alu_op
);
  logic [OPC_W-1:0] opc;
  logic             exec_go;
  logic             jz_take;
  logic [PW-1:0]    off_ext;
  logic [PW-1:0]    pc_nxt;
  logic [IW-1:0]    ir_nxt;
  phase_t           ph_nxt;

  assign opc     = ir[IW-1 -: OPC_W];
  assign exec_go = run && (phase == PH_EXEC);
  assign off_ext = PW'($signed(ir[7:0]));
  assign jz_take = exec_go && (opc == OP_JZ) && ra_zero;

  always_comb begin
    rf_we  = exec_go && ((opc == OP_LD) || (opc == OP_ADD) ||
                         (opc == OP_SUB) || (opc == OP_LDK));
    dm_we  = exec_go && (opc == OP_ST);
    wb_mem = (opc == OP_LD);
    if (opc == OP_SUB)      alu_op = ALU_SUB;
    else if (opc == OP_LDK) alu_op = ALU_PASSK;
    else                    alu_op = ALU_ADD;
  end

  always_comb begin
    ph_nxt = phase;
    pc_nxt = pc;
    ir_nxt = ir;
    unique case (phase)
      PH_FETCH: begin
        ir_nxt = instr;
        pc_nxt = pc + PW'(1);
        ph_nxt = PH_DECODE;
      end
      PH_DECODE: ph_nxt = PH_EXEC;
      default: begin
        ph_nxt = PH_FETCH;
        if (jz_take) pc_nxt = pc - PW'(1) + off_ext;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      phase <= PH_FETCH;
      ir    <= '0;
    end else if (run) begin
      pc    <= pc_nxt;
      phase <= ph_nxt;
      ir    <= ir_nxt;
    end
  end

  // R2
  phase_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == PH_FETCH) |=> (phase == PH_DECODE));
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == PH_FETCH) |=> (pc == $past(pc) + PW'(1)));
  // R2
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(pc) && $stable(phase)));
  // R6
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == PH_EXEC && opc != OP_JZ) |=> $stable(pc));
endmodule

// File: rtl/mcp_top.sv
module mcp_top
  import mcp_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_en,
  input  logic              ld_sel,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DW-1:0]     ld_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [ADDR_W-1:0] pc,
  output logic [1:0]        phase
);
  localparam int RW = $clog2(NREG);

  logic [1:0]        rs_q;
  logic              rst_s_n;
  phase_t            ph;
  logic [DW-1:0]     ir, instr, imem_rb, dmem_rd, dmem_rb;
  logic              rf_we, dm_we, wb_mem;
  alu_op_t           alu_op;
  logic [DW-1:0]     va, vb, vc, alu_y, wb_val, konst;
  logic              dmem_we, imem_we;
  logic [ADDR_W-1:0] dmem_wa;
  logic [DW-1:0]     dmem_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  mcp_ctrl #(.IW(DW), .PW(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .run(run), .instr(instr),
    .ra_zero(va == '0), .pc(pc), .phase(ph), .ir(ir),
    .rf_we(rf_we), .dm_we(dm_we), .wb_mem(wb_mem), .alu_op(alu_op)
  );
  assign phase = ph;

  assign konst  = DW'(ir[7:0]);
  assign wb_val = wb_mem ? dmem_rd : alu_y;

  mcp_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .we(rf_we), .wsel(ir[8 +: RW]), .wdata(wb_val),
    .sel_a(ir[8 +: RW]), .sel_b(ir[4 +: RW]), .sel_c(ir[0 +: RW]),
    .val_a(va), .val_b(vb), .val_c(vc)
  );

  mcp_alu #(.DW(DW)) u_alu (
    .op(alu_op), .opa(vb), .opb(vc), .konst(konst), .res(alu_y)
  );

  assign imem_we = ld_en && !ld_sel;
  assign dmem_we = (ld_en && ld_sel) || dm_we;
  assign dmem_wa = (ld_en && ld_sel) ? ld_addr : ir[7:0];
  assign dmem_wd = (ld_en && ld_sel) ? ld_data : va;

  mcp_mem #(.DW(DW), .AW(ADDR_W)) u_imem (
    .clk(clk), .we(imem_we), .waddr(ld_addr), .wdata(ld_data),
    .raddr_a(pc), .rdata_a(instr), .raddr_b(rd_addr), .rdata_b(imem_rb)
  );

  mcp_mem #(.DW(DW), .AW(ADDR_W)) u_dmem (
    .clk(clk), .we(dmem_we), .waddr(dmem_wa), .wdata(dmem_wd),
    .raddr_a(ir[7:0]), .rdata_a(dmem_rd), .raddr_b(rd_addr), .rdata_b(dmem_rb)
  );

  assign rd_data = ld_sel ? dmem_rb : imem_rb;

  // R3
  store_phase_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    dm_we |-> (ph == PH_EXEC && run));
  // R7
  noop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ph == PH_EXEC && ir[DW-1 -: OPC_W] >= 4'h6) |-> (!rf_we && !dm_we));
endmodule

// File: tb/mcp_top_test.sv
module mcp_top_test;
  logic        clk = 1'b0;
  logic        rst_n, run, ld_en, ld_sel;
  logic [7:0]  ld_addr, rd_addr, pc;
  logic [15:0] ld_data, rd_data;
  logic [1:0]  phase;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  mcp_top uut (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pc(pc), .phase(phase)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic sel, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek(input logic sel, input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    ld_sel = sel; rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic [15:0] exp_d13(input logic [15:0] a);
    return (a == 16'h0) ? 16'hDEAD : 16'h00AA;
  endfunction

  task automatic one_run(input logic [15:0] a, input logic [15:0] b,
                         input logic [7:0] k, input logic [3:0] nop, input bit timing);
    logic [15:0] prog [18];
    logic [15:0] v;
    prog[0]  = 16'h3F00; prog[1]  = 16'h0100; prog[2]  = 16'h0201;
    prog[3]  = 16'h2312; prog[4]  = 16'h4412; prog[5]  = {nop, 12'h300};
    prog[6]  = 16'h1309; prog[7]  = 16'h140A; prog[8]  = {8'h35, k};
    prog[9]  = 16'h150B; prog[10] = 16'h110C; prog[11] = 16'h5103;
    prog[12] = 16'h36AA; prog[13] = 16'h160D; prog[14] = 16'h5F03;
    prog[15] = 16'h3755; prog[16] = 16'h170E; prog[17] = 16'h5FFE;
    run = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < 18; i++) put(1'b0, 8'(i), prog[i]);
    put(1'b1, 8'd0, a);
    put(1'b1, 8'd1, b);
    for (int i = 9; i < 15; i++) put(1'b1, 8'(i), 16'hDEAD);
    if (timing) begin
      peek(1'b0, 8'd5, v);
      chk("R8 program readback", v, {nop, 12'h300});
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    if (timing) begin
      chk("R1 pc", 16'(pc), 16'h0);
      chk("R1 phase", 16'(phase), 16'h0);
    end
    run = 1'b1;
    if (timing) begin
      @(negedge clk); chk("R2 phase decode", 16'(phase), 16'h1);
      chk("R2 pc after fetch", 16'(pc), 16'h1);
      @(negedge clk); chk("R2 phase exec", 16'(phase), 16'h2);
      @(negedge clk); chk("R2 phase fetch", 16'(phase), 16'h0);
      chk("R2 pc hold", 16'(pc), 16'h1);
      run = 1'b0;
      repeat (4) @(negedge clk);
      chk("R2 frozen phase", 16'(phase), 16'h0);
      chk("R2 frozen pc", 16'(pc), 16'h1);
      run = 1'b1;
    end
    repeat (150) @(negedge clk);
    run = 1'b0;
    peek(1'b1, 8'd9, v);  chk("R4 add", v, a + b);
    peek(1'b1, 8'd10, v); chk("R4 sub", v, a - b);
    peek(1'b1, 8'd11, v); chk("R5 const", v, {8'h00, k});
    peek(1'b1, 8'd12, v); chk("R3 load/store", v, a);
    peek(1'b1, 8'd0, v);  chk("R7 noop data", v, a);
    peek(1'b1, 8'd13, v); chk("R6 forward jz", v, exp_d13(a));
    peek(1'b1, 8'd14, v); chk("R6 backward jz", v, 16'h0055);
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; ld_en = 1'b0; ld_sel = 1'b0;
    ld_addr = '0; ld_data = '0; rd_addr = '0;
    void'($urandom(32'd4242));
    one_run(16'h0000, 16'h0005, 8'h00, 4'h6, 1'b1);
    one_run(16'h0007, 16'h0007, 8'hFF, 4'hF, 1'b0);
    one_run(16'hFFFF, 16'h0001, 8'h80, 4'h9, 1'b0);
    one_run(16'h0003, 16'h8000, 8'h01, 4'hC, 1'b0);
    for (int it = 0; it < 12; it++)
      one_run(16'($urandom), 16'($urandom), 8'($urandom),
              4'(6 + $urandom % 10), 1'b0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule